// File: doc/BRIEF.md
# Five-State Non-Binary Sequence Counter

This block is a three-bit synchronous counter that walks a fixed loop of five codes instead of a binary count. Written as C B A (C most significant), the loop is 000, 100, 111, 010, 011 and back to 000. The codes 001, 101 and 110 are not part of the loop. The block marks them as unreachable when it derives its next-state logic, but it still defines where each of them goes.

The next-state logic is built from the excitation rule of one storage-element style, chosen by a parameter:

- Data style: the input of each bit is its next value.
- Toggle style: each bit flips when its toggle input is high.
- Set/reset pair style: each bit follows the characteristic equation next = J·~Q | ~K·Q.

All three styles share one full eight-entry transition map. They are therefore interchangeable.

The block is used wherever a short repeating phase pattern is needed. A count enable advances it, and a synchronous reset returns it to 000. A preset port forces any code into the register, including the off-loop codes. It exists so that recovery from those codes can be exercised. A combinational flag reports when the register holds an off-loop code.

Top module: `seqctr_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state becomes 000 at that edge, whatever `preset_en`, `preset_code` and `cnt_en` are doing.
- R2: When `rst`, `preset_en` and `cnt_en` are all low at an edge, the state keeps its value, including when that value is an off-loop code.
- R3: With `cnt_en` high (and `rst` and `preset_en` low), each edge moves the state {C,B,A} along the loop 000→100→111→010→011→000.
- R4: `unused_flag` is high in exactly the cycles in which the state is 001, 101 or 110, and low for the five loop codes.
- R5: When `preset_en` is high and `rst` is low at an edge, the state takes the value of `preset_code`. Here `preset_code[2]`, `[1]` and `[0]` load C, B and A. A preset overrides `cnt_en`.
- R6: An enabled step from an off-loop code goes 001→100, 101→110 and 110→010.
- R7: From any off-loop code, at most two enabled steps bring the state back into the five-code loop. The counter has no lock-up state.
- R8: All three values of the parameter `FF_KIND` (0 data, 1 toggle, 2 set/reset pair) give identical transitions from all eight codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 000 |
| cnt_en | input | 1 | Advance one step per edge when high |
| preset_en | input | 1 | Test hook: load `preset_code` at the next edge |
| preset_code | input | 3 | Code to load; bit 2 = C, bit 1 = B, bit 0 = A |
| q_c | output | 1 | State bit C (most significant) |
| q_b | output | 1 | State bit B |
| q_a | output | 1 | State bit A (least significant) |
| unused_flag | output | 1 | High while the state is an off-loop code |

## Verification
The properties assume that control inputs are stable and known at each rising edge. They also assume that the priority among `rst`, `preset_en` and `cnt_en` is the only thing that decides which transition applies. The recovery property counts only enabled steps taken while the flag is high, so holds and presets between them do not break it. The stimulus changes inputs one time unit after each rising edge and never leaves a control input undriven. It enters off-loop codes only through the preset hook. All three parameter variants run side by side on the same inputs.

// File: rtl/seqctr_pkg.sv
`timescale 1ns/1ps
package seqctr_pkg;

    typedef enum logic [1:0] {
        FF_D  = 2'd0,
        FF_T  = 2'd1,
        FF_JK = 2'd2
    } ff_kind_e;

    localparam int unsigned STATE_W  = 3;
    localparam int unsigned N_UNUSED = 3;

    typedef struct packed {
        logic c;
        logic b;
        logic a;
    } cba_t;

    typedef struct packed {
        logic j;
        logic k;
    } jk_pair_t;

    localparam cba_t CBA_HOME = 3'b000;

    localparam logic [STATE_W-1:0] OFF_LOOP_CODES [0:N_UNUSED-1] = '{3'b001, 3'b101, 3'b110};

    function automatic logic jk_char(input jk_pair_t p, input logic q);
        return (p.j & ~q) | (~p.k & q);
    endfunction

    function automatic logic t_char(input logic t, input logic q);
        return t ^ q;
    endfunction

endpackage

// File: rtl/seqctr_next.sv
`timescale 1ns/1ps
module seqctr_next
    import seqctr_pkg::*;
#(
    parameter ff_kind_e KIND = FF_JK
) (
    input  cba_t cur,
    output cba_t nxt
);

    generate
        if (KIND == FF_D) begin : g_data
            cba_t d_in;
            always_comb begin
                d_in.c = ~cur.b;
                d_in.b = cur.c | (cur.b & ~cur.a);
                d_in.a = ~cur.a & (cur.c ^ cur.b);
            end
            assign nxt = d_in;
        end else if (KIND == FF_T) begin : g_toggle
            cba_t t_in;
            always_comb begin
                t_in.c = ~(cur.c ^ cur.b);
                t_in.b = (cur.c & ~cur.b) | (~cur.c & cur.b & cur.a);
                t_in.a = cur.a | (cur.c ^ cur.b);
            end
            assign nxt.c = t_char(t_in.c, cur.c);
            assign nxt.b = t_char(t_in.b, cur.b);
            assign nxt.a = t_char(t_in.a, cur.a);
        end else begin : g_jk
            jk_pair_t jk_c;
            jk_pair_t jk_b;
            jk_pair_t jk_a;
            always_comb begin
                jk_c.j = ~cur.b;
                jk_c.k = cur.b;
                jk_b.j = cur.c;
                jk_b.k = ~cur.c & cur.a;
                jk_a.j = cur.c ^ cur.b;
                jk_a.k = 1'b1;
            end
            assign nxt.c = jk_char(jk_c, cur.c);
            assign nxt.b = jk_char(jk_b, cur.b);
            assign nxt.a = jk_char(jk_a, cur.a);
        end
    endgenerate

endmodule

// File: rtl/seqctr_unused_det.sv
`timescale 1ns/1ps
module seqctr_unused_det
    import seqctr_pkg::*;
(
    input  cba_t cur,
    output logic hit
);

    logic [N_UNUSED-1:0] match;

    generate
        for (genvar i = 0; i < N_UNUSED; i++) begin : g_cmp
            assign match[i] = (cur == cba_t'(OFF_LOOP_CODES[i]));
        end
    endgenerate

    assign hit = |match;

endmodule

// File: rtl/seqctr_top.sv
`timescale 1ns/1ps
module seqctr_top
    import seqctr_pkg::*;
#(
    parameter ff_kind_e FF_KIND = FF_JK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         preset_en,
    input  logic [2:0]   preset_code,
    output logic         q_c,
    output logic         q_b,
    output logic         q_a,
    output logic         unused_flag
);

    typedef struct packed {
        cba_t st;
    } ctr_regs_t;

    ctr_regs_t regs_d;
    ctr_regs_t regs_q;
    cba_t      step_val;

    seqctr_next #(
        .KIND (FF_KIND)
    ) u_next (
        .cur (regs_q.st),
        .nxt (step_val)
    );

    seqctr_unused_det u_det (
        .cur (regs_q.st),
        .hit (unused_flag)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.st = CBA_HOME;
        end else if (preset_en) begin
            regs_d.st = cba_t'(preset_code);
        end else if (cnt_en) begin
            regs_d.st = step_val;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign q_c = regs_q.st.c;
    assign q_b = regs_q.st.b;
    assign q_a = regs_q.st.a;

endmodule

// File: rtl/seqctr_chk.sv
`timescale 1ns/1ps
module seqctr_chk (
    input logic       clk,
    input logic       rst,
    input logic       cnt_en,
    input logic       preset_en,
    input logic [2:0] preset_code,
    input logic       q_c,
    input logic       q_b,
    input logic       q_a,
    input logic       unused_flag
);

    logic [2:0] st;
    logic       adv;
    logic [1:0] off_steps_q;

    assign st  = {q_c, q_b, q_a};
    assign adv = !rst && !preset_en && cnt_en;

    always_ff @(posedge clk) begin
        if (rst || preset_en || !unused_flag) begin
            off_steps_q <= 2'd0;
        end else if (cnt_en && off_steps_q != 2'd3) begin
            off_steps_q <= off_steps_q + 2'd1;
        end
    end

    assert_reset_home_R1: assert property (@(posedge clk) rst |=> st == 3'b000);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!preset_en && !cnt_en) |=> $stable(st));

    assert_loop_a_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && st == 3'b000) |=> st == 3'b100);
    assert_loop_b_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && st == 3'b100) |=> st == 3'b111);
    assert_loop_c_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && st == 3'b111) |=> st == 3'b010);
    assert_loop_d_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && st == 3'b010) |=> st == 3'b011);
    assert_loop_e_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && st == 3'b011) |=> st == 3'b000);

    assert_flag_code_R4: assert property (@(posedge clk) disable iff (rst)
        unused_flag |-> (st == 3'b001 || st == 3'b101 || st == 3'b110));

    assert_preset_R5: assert property (@(posedge clk) disable iff (rst)
        preset_en |=> st == $past(preset_code));

    assert_off_001_R6: assert property (@(posedge clk) disable iff (rst)
        (adv && st == 3'b001) |=> st == 3'b100);
    assert_off_101_R6: assert property (@(posedge clk) disable iff (rst)
        (adv && st == 3'b101) |=> st == 3'b110);
    assert_off_110_R6: assert property (@(posedge clk) disable iff (rst)
        (adv && st == 3'b110) |=> st == 3'b010);

    assert_recover_R7: assert property (@(posedge clk) disable iff (rst)
        unused_flag |-> off_steps_q < 2'd2);

endmodule

bind seqctr_top seqctr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_en      (cnt_en),
    .preset_en   (preset_en),
    .preset_code (preset_code),
    .q_c         (q_c),
    .q_b         (q_b),
    .q_a         (q_a),
    .unused_flag (unused_flag)
);

// File: tb/seqctr_top_tb.sv
`timescale 1ns/1ps
module seqctr_top_tb;

    localparam int WD_CYCLES = 5000;

    // vector layout: {rst, preset_en, preset_code[2:0], cnt_en, expected CBA[2:0]}
    localparam logic [8:0] VEC [0:17] = '{
        9'b1_0_000_0_000,
        9'b0_0_000_1_100,
        9'b0_0_000_1_111,
        9'b0_0_000_0_111,
        9'b0_0_000_1_010,
        9'b0_0_000_1_011,
        9'b0_0_000_1_000,
        9'b0_0_000_1_100,
        9'b0_1_001_1_001,
        9'b0_0_000_1_100,
        9'b0_1_101_0_101,
        9'b0_0_000_0_101,
        9'b0_0_000_1_110,
        9'b0_0_000_1_010,
        9'b0_1_110_0_110,
        9'b0_0_000_1_010,
        9'b1_1_011_1_000,
        9'b0_0_000_1_100
    };

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       cnt_en = 1'b0;
    logic       preset_en = 1'b0;
    logic [2:0] preset_code = 3'b000;

    logic [2:0] st_d, st_t, st_jk;
    logic       fl_d, fl_t, fl_jk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    seqctr_top #(.FF_KIND(seqctr_pkg::FF_D)) u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .preset_en(preset_en),
        .preset_code(preset_code), .q_c(st_d[2]), .q_b(st_d[1]), .q_a(st_d[0]),
        .unused_flag(fl_d));

    seqctr_top #(.FF_KIND(seqctr_pkg::FF_T)) u_dut_t (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .preset_en(preset_en),
        .preset_code(preset_code), .q_c(st_t[2]), .q_b(st_t[1]), .q_a(st_t[0]),
        .unused_flag(fl_t));

    seqctr_top #(.FF_KIND(seqctr_pkg::FF_JK)) u_dut_jk (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .preset_en(preset_en),
        .preset_code(preset_code), .q_c(st_jk[2]), .q_b(st_jk[1]), .q_a(st_jk[0]),
        .unused_flag(fl_jk));

    function automatic logic off_loop(input logic [2:0] s);
        return (s == 3'b001) || (s == 3'b101) || (s == 3'b110);
    endfunction

    function automatic logic [2:0] ref_next(input logic [2:0] s);
        case (s)
            3'b000: return 3'b100;
            3'b100: return 3'b111;
            3'b111: return 3'b010;
            3'b010: return 3'b011;
            3'b011: return 3'b000;
            3'b001: return 3'b100;
            3'b101: return 3'b110;
            default: return 3'b010;
        endcase
    endfunction

    task automatic chk(input string req, input string who, input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, who, got, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [2:0] exp);
        chk(req, "data", st_d, exp);
        chk(req, "toggle", st_t, exp);
        chk(req, "jk", st_jk, exp);
        chk("R4", "flag data", {2'b00, fl_d}, {2'b00, off_loop(exp)});
        chk("R4", "flag toggle", {2'b00, fl_t}, {2'b00, off_loop(exp)});
        chk("R4", "flag jk", {2'b00, fl_jk}, {2'b00, off_loop(exp)});
    endtask

    task automatic drive(input logic r, input logic pe, input logic [2:0] pc, input logic en);
        rst = r; preset_en = pe; preset_code = pc; cnt_en = en;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(WD_CYCLES * 4);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        tick();
        for (int i = 0; i < 18; i++) begin
            string tag;
            drive(VEC[i][8], VEC[i][7], VEC[i][6:4], VEC[i][3]);
            tick();
            if (VEC[i][8])      tag = "R1";
            else if (VEC[i][7]) tag = "R5";
            else if (!VEC[i][3]) tag = "R2";
            else if (off_loop(VEC[i][2:0]) || i == 9 || i == 13 || i == 15) tag = "R6";
            else                tag = "R3";
            chk_all(tag, VEC[i][2:0]);
        end

        // R8: every variant agrees with the full map from all eight codes
        for (int code = 0; code < 8; code++) begin
            drive(1'b0, 1'b1, 3'(code), 1'b0);
            tick();
            chk_all("R5", 3'(code));
            drive(1'b0, 1'b0, 3'b000, 1'b1);
            tick();
            chk_all("R8", ref_next(3'(code)));
        end

        // R7: recovery within two enabled steps from each off-loop code
        for (int k = 0; k < 3; k++) begin
            logic [2:0] start;
            logic [2:0] exp_s;
            start = (k == 0) ? 3'b001 : (k == 1) ? 3'b101 : 3'b110;
            drive(1'b0, 1'b1, start, 1'b0);
            tick();
            drive(1'b0, 1'b0, 3'b000, 1'b1);
            exp_s = start;
            for (int s = 0; s < 2; s++) begin
                tick();
                exp_s = ref_next(exp_s);
            end
            chk_all("R7", exp_s);
            chk("R7", "in loop", {2'b00, fl_d | fl_t | fl_jk}, 3'b000);
        end

        // R1: reset wins over preset and enable from an off-loop code
        drive(1'b0, 1'b1, 3'b101, 1'b0);
        tick();
        drive(1'b1, 1'b1, 3'b110, 1'b1);
        tick();
        chk_all("R1", 3'b000);
        drive(1'b0, 1'b0, 3'b000, 1'b0);
        tick();
        chk_all("R2", 3'b000);

        finish_run();
    end

endmodule